// File: doc/BRIEF.md
# Page Assembly Buffer Loader

The block collects one flash page worth of data from a 16-bit bus. All data goes to one command address. Software first switches the block into page mode, which clears the internal word pointer. Each write to the load address then holds the next word in a one-word staging register. A copy engine moves that word into the page buffer over a fixed number of cycles. The pointer steps forward after every accepted load, so 64 loads fill a 128-byte page in ascending word order.

While a copy is in flight, the block holds off the bus with a stall for any write or flash read that arrives. A stalled write is not taken until the copy has finished. Loads made outside page mode are dropped. Loads made once the page is full are dropped and raise a sticky overflow flag, which clears on the next page entry. A read port returns any buffer word by index. Moving the buffer into the flash array is handled elsewhere.

Top module: `page_loader`

## Requirements
- R1: After reset, page mode is off, the pointer (`word_cnt_o`) is 0, `stall_o` and `overflow_o` are low, and every buffer word reads as 0.
- R2: A load is a write (`bus_wr_i`=1) with `bus_addr_i` equal to LOAD_ADDR (default 8'hF2). Writes to any other address change neither the pointer nor the buffer.
- R3: A page entry pulse (`page_enter_i`) sets the pointer to 0. Each accepted load stores its data at buffer index equal to the pointer, then adds 1 to the pointer.
- R4: A word accepted at clock edge E appears on the read port after edge E+COPY_CYCLES (default 4). Before that edge, the read port shows the old contents of that index.
- R5: `stall_o` is high exactly when a copy is in flight and `bus_wr_i` or `flash_rd_i` is high. A write that arrives right after a load is therefore stalled for COPY_CYCLES cycles. A stalled write is not accepted.
- R6: With the pointer at PAGE_BYTES/2 (a full page), a further load is discarded: buffer and pointer stay unchanged and `overflow_o` goes high. The flag stays high until the next page entry clears it.
- R7: A load while page mode is off has no effect on the buffer, the pointer or `overflow_o`. The page mode flag is set by `page_enter_i` and cleared by `page_exit_i`, and entry takes priority when both are high.
- R8: `rd_data_o` returns the buffer word at `rd_idx_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_enter_i | input | 1 | Enter page mode, clear pointer and overflow |
| page_exit_i | input | 1 | Leave page mode |
| bus_wr_i | input | 1 | Bus write request |
| bus_addr_i | input | ADDR_W | Low bits of the write address |
| bus_wdata_i | input | WORD_W | Write data |
| flash_rd_i | input | 1 | Flash read request |
| stall_o | output | 1 | Hold the current bus access |
| overflow_o | output | 1 | A load hit a full page (sticky) |
| word_cnt_o | output | $clog2(WORDS+1) | Current word pointer |
| rd_idx_i | input | $clog2(WORDS) | Buffer read index |
| rd_data_o | output | WORD_W | Buffer word at rd_idx_i |

## Verification
The bench builds the block with PAGE_BYTES=32 (16 words) and COPY_CYCLES=3. With these values, two full fill passes using different data patterns check every buffer index, and the overflow boundary is reached after a short run. The shorter copy window lets the bench check the read port before, during and after the copy cycle by cycle. It also counts stall lengths for back-to-back loads, for flash reads and for writes to other addresses.

// File: rtl/page_loader_pkg.sv
package page_loader_pkg;
  // outcome of a write to the load address in the current cycle
  typedef enum logic [1:0] {
    LD_NONE     = 2'd0,
    LD_ACCEPT   = 2'd1,
    LD_OVERFLOW = 2'd2,
    LD_DROP     = 2'd3
  } ld_kind_e;
endpackage

// File: rtl/page_loader_ptr.sv
module page_loader_ptr
  import page_loader_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic             cmd_i,
  input  logic             busy_i,
  output ld_kind_e         kind_o,
  output logic [CNT_W-1:0] ptr_o,
  output logic             page_mode_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);

  logic [CNT_W-1:0] ptr_q;
  logic             mode_q, ovf_q;

  always_comb begin
    kind_o = LD_NONE;
    if (cmd_i && !busy_i) begin
      if (!mode_q)           kind_o = LD_DROP;
      else if (ptr_q == FULL) kind_o = LD_OVERFLOW;
      else                   kind_o = LD_ACCEPT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (enter_i) begin
      ptr_q  <= '0;
      mode_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      if (exit_i) mode_q <= 1'b0;
      if (kind_o == LD_ACCEPT) ptr_q <= ptr_q + CNT_W'(1);
      if (kind_o == LD_OVERFLOW) ovf_q <= 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign page_mode_o = mode_q;
  assign ovf_o       = ovf_q;

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == LD_ACCEPT && !enter_i) |=> ptr_q == $past(ptr_q) + CNT_W'(1));
  // R6
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= FULL);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !enter_i) |=> ovf_q);
  // R7
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == LD_DROP && !enter_i) |=> (ptr_q == $past(ptr_q) && ovf_q == $past(ovf_q)));
endmodule

// File: rtl/page_loader_copy.sv
module page_loader_copy #(
  parameter int WORD_W      = 16,
  parameter int IDX_W       = 6,
  parameter int COPY_CYCLES = 4,
  parameter int CYC_W       = $clog2(COPY_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [CYC_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CYC_W'(COPY_CYCLES);
      idx_q  <= idx_i;
      data_q <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CYC_W'(1);
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign we_o    = (cnt_q == CYC_W'(1));
  assign widx_o  = idx_q;
  assign wdata_o = data_q;

  // R4
  copy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CYC_W'(COPY_CYCLES) && wdata_o == $past(data_i)));
  // R4
  copy_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> $stable(wdata_o));
  // R5
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/page_loader_buf.sv
module page_loader_buf #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/page_loader.sv
module page_loader
  import page_loader_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          PAGE_BYTES  = 128,
  parameter int          COPY_CYCLES = 4,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  LOAD_ADDR   = 8'hF2,
  localparam int         WORDS       = PAGE_BYTES / (WORD_W / 8),
  localparam int         IDX_W       = $clog2(WORDS),
  localparam int         CNT_W       = $clog2(WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_enter_i,
  input  logic              page_exit_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic              flash_rd_i,
  output logic              stall_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  word_cnt_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int CYC_W = $clog2(COPY_CYCLES + 1);

  ld_kind_e          kind;
  logic              cmd, busy, page_mode, we;
  logic [CNT_W-1:0]  ptr;
  logic [IDX_W-1:0]  widx;
  logic [WORD_W-1:0] wdata;

  assign cmd     = bus_wr_i && (bus_addr_i == ADDR_W'(LOAD_ADDR));
  assign stall_o = busy && (bus_wr_i || flash_rd_i);

  page_loader_ptr #(.WORDS(WORDS), .CNT_W(CNT_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (page_enter_i),
    .exit_i     (page_exit_i),
    .cmd_i      (cmd),
    .busy_i     (busy),
    .kind_o     (kind),
    .ptr_o      (ptr),
    .page_mode_o(page_mode),
    .ovf_o      (overflow_o)
  );

  page_loader_copy #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .COPY_CYCLES(COPY_CYCLES), .CYC_W(CYC_W)
  ) u_copy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(kind == LD_ACCEPT),
    .idx_i  (ptr[IDX_W-1:0]),
    .data_i (bus_wdata_i),
    .busy_o (busy),
    .we_o   (we),
    .widx_o (widx),
    .wdata_o(wdata)
  );

  page_loader_buf #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (widx),
    .wdata_i(wdata),
    .ridx_i (rd_idx_i),
    .rdata_o(rd_data_o)
  );

  assign word_cnt_o = ptr;

  // R5
  stall_blocks_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> kind != LD_ACCEPT);
  // R7
  accept_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == LD_ACCEPT |-> page_mode);
  // R5
  busy_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == LD_ACCEPT |=> busy);
  // R2
  other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd && !page_enter_i) |=> word_cnt_o == $past(word_cnt_o));
endmodule

// File: tb/sim_page_loader.sv
`timescale 1ns/1ps
module sim_page_loader;
  localparam int WW = 16, PB = 32, CC = 3, AW = 8;
  localparam int NW = PB / (WW / 8);
  localparam int IW = $clog2(NW);
  localparam int CW = $clog2(NW + 1);
  localparam logic [7:0] LA = 8'hF2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enter = 0, leave = 0, wr = 0, frd = 0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic stall, ovf;
  logic [CW-1:0] cnt;
  logic [IW-1:0] ridx = '0;
  logic [WW-1:0] rdata;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  page_loader #(.WORD_W(WW), .PAGE_BYTES(PB), .COPY_CYCLES(CC), .ADDR_W(AW), .LOAD_ADDR(LA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .page_enter_i(enter), .page_exit_i(leave),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .flash_rd_i(frd),
    .stall_o(stall), .overflow_o(ovf), .word_cnt_o(cnt),
    .rd_idx_i(ridx), .rd_data_o(rdata)
  );

  function automatic logic [WW-1:0] pat(input int k, input int s);
    return WW'((k * 16'h1F3D + s * 16'h0B71) ^ 16'hC0DE);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives a write at a negedge, waits out stalls, returns just after the accepting edge
  task automatic bus_write(input logic [7:0] a, input logic [WW-1:0] d, output int stalls);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; stalls = 0;
    #1;
    while (stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    wr = 1'b0; frd = 1'b0;
  endtask

  task automatic enter_page();
    @(negedge clk); enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    #1;
  endtask

  task automatic read_chk(input int i, input logic [WW-1:0] exp, input string req);
    @(negedge clk);
    ridx = IW'(i);
    #1;
    chk(rdata == exp, req, int'(rdata), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stall == 0, "R1 stall", int'(stall), 0);
    chk(ovf == 0, "R1 overflow", int'(ovf), 0);
    chk(cnt == 0, "R1 pointer", int'(cnt), 0);
    for (int i = 0; i < NW; i++) read_chk(i, '0, "R1 buffer");

    // R7 load outside page mode
    bus_write(LA, 16'hBEEF, st); idle();
    repeat (CC + 1) @(negedge clk);
    #1;
    chk(cnt == 0, "R7 pointer", int'(cnt), 0);
    chk(ovf == 0, "R7 overflow", int'(ovf), 0);
    read_chk(0, '0, "R7 buffer");

    // R3/R5 full sweep, back-to-back loads
    enter_page();
    chk(cnt == 0, "R3 entry pointer", int'(cnt), 0);
    for (int k = 0; k < NW; k++) begin
      bus_write(LA, pat(k, 1), st);
      chk(st == (k == 0 ? 0 : CC), "R5 back-to-back stall", st, (k == 0 ? 0 : CC));
      #1;
      chk(int'(cnt) == k + 1, "R3 pointer step", int'(cnt), k + 1);
    end
    idle();
    repeat (CC + 1) @(negedge clk);
    for (int k = 0; k < NW; k++) read_chk(k, pat(k, 1), "R3 R8 sweep1");

    // R6 overflow
    bus_write(LA, 16'hDEAD, st); idle();
    #1;
    chk(ovf == 1, "R6 overflow set", int'(ovf), 1);
    chk(int'(cnt) == NW, "R6 pointer held", int'(cnt), NW);
    repeat (CC + 1) @(negedge clk);
    read_chk(0, pat(0, 1), "R6 buffer first");
    read_chk(NW - 1, pat(NW - 1, 1), "R6 buffer last");
    repeat (3) @(negedge clk);
    chk(ovf == 1, "R6 overflow sticky", int'(ovf), 1);
    enter_page();
    chk(ovf == 0, "R6 overflow cleared", int'(ovf), 0);
    chk(cnt == 0, "R3 re-entry pointer", int'(cnt), 0);

    // R4 copy latency
    @(negedge clk); ridx = '0;
    bus_write(LA, 16'h5A5A, st); idle();
    #1;
    chk(rdata == pat(0, 1), "R4 old at E+0", int'(rdata), int'(pat(0, 1)));
    for (int c = 1; c < CC; c++) begin
      @(negedge clk); #1;
      chk(rdata == pat(0, 1), "R4 old during copy", int'(rdata), int'(pat(0, 1)));
    end
    @(negedge clk); #1;
    chk(rdata == 16'h5A5A, "R4 new after copy", int'(rdata), 16'h5A5A);

    // R2 other address in page mode
    bus_write(LA ^ 8'h01, 16'h1111, st); idle();
    repeat (CC + 1) @(negedge clk);
    #1;
    chk(cnt == 1, "R2 pointer", int'(cnt), 1);
    read_chk(1, pat(1, 1), "R2 buffer");

    // R5 flash read stall window
    bus_write(LA, 16'h2222, st);
    @(negedge clk); wr = 1'b0; frd = 1'b1;
    st = 0;
    #1;
    while (stall && st < 10) begin
      st++;
      @(negedge clk); #1;
    end
    chk(st == CC, "R5 flash read stall", st, CC);
    chk(stall == 0, "R5 read released", int'(stall), 0);
    frd = 1'b0;
    // R5 no request, no stall
    bus_write(LA, 16'h3333, st); idle();
    #1;
    chk(stall == 0, "R5 idle no stall", int'(stall), 0);
    // R5 write to other address is stalled too
    bus_write(LA ^ 8'h10, 16'h0, st); idle();
    chk(st == CC - 1, "R5 other write stall", st, CC - 1);
    repeat (CC + 1) @(negedge clk);
    read_chk(1, 16'h2222, "R3 idx1");
    read_chk(2, 16'h3333, "R3 idx2");

    // second sweep, new pattern
    enter_page();
    for (int k = 0; k < NW; k++) bus_write(LA, pat(k, 2), st);
    idle();
    repeat (CC + 1) @(negedge clk);
    for (int k = 0; k < NW; k++) read_chk(k, pat(k, 2), "R3 R8 sweep2");

    // R7 page exit ends acceptance
    enter_page();
    bus_write(LA, 16'h4444, st);
    bus_write(LA, 16'h5555, st); idle();
    @(negedge clk); leave = 1'b1;
    @(negedge clk); leave = 1'b0;
    repeat (CC) @(negedge clk);
    bus_write(LA, 16'h6666, st); idle();
    repeat (CC + 1) @(negedge clk);
    #1;
    chk(cnt == 2, "R7 exit pointer", int'(cnt), 2);
    chk(ovf == 0, "R7 exit overflow", int'(ovf), 0);
    read_chk(2, pat(2, 2), "R7 exit buffer");
    read_chk(1, 16'h5555, "R7 last in mode");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule